// File: doc/BRIEF.md
# Event-State Page Controller for Queue Descriptors

This block serves loads and stores that land in a window of memory-mapped pages, one pair of pages for each event-queue descriptor. The even page of a pair acts on the descriptor's notification state bits and the odd page on its escalation state bits. Each state is two bits: a pending bit P (bit 1) and a queued bit Q (bit 0). The low twelve address bits inside a page select the operation: trigger, end-of-interrupt (EOI), read, forced set, or inject.

The state bits live in an external store. The block reads that store combinationally through a read port and writes it through a write port in the cycle the request is presented. A write is issued only when the value actually changes. A load returns its data one cycle after the request. A notify pulse, carrying the descriptor index and page parity, is raised one cycle after a store that calls for one. A one-bit configuration input selects 4 KB or 64 KB pages. Routing of the notification is left to the consumer of the pulse.

Top module: `pq_page_ctrl`

## Requirements
- R1: The descriptor index is `req_addr >> (S+1)`, where S is 12 when `cfg_page64`=0 and 16 when it is 1. Address bit S selects the page: 0 means even (notification), 1 means odd (escalation). The in-page offset is `req_addr[11:0]`, and any other bits inside a 64 KB page are ignored.
- R2: Trigger moves the state as follows: 00 goes to 10 and requests a notify, 10 goes to 11, 11 stays 11, and 01 stays 01. Only the 00 case requests a notify.
- R3: EOI clears P. If Q was 1, the state becomes 10 and the EOI result is 1. Otherwise the state becomes 00 and the result is 0.
- R4: A load at offset 0x000–0x7FF performs EOI. It returns the EOI result in data bit 0, with all other bits 0, and raises no notify.
- R5: A load at offset 0x800–0xBFF returns the state in data bits [1:0] and leaves the state unchanged.
- R6: A load at offset 0xC00–0xFFF sets the state to `offset[9:8]` and returns the old state in bits [1:0].
- R7: A store at offset 0x000–0x3FF performs trigger and pulses notify when trigger requests it.
- R8: A store at offset 0x400–0x7FF performs EOI and pulses notify when the EOI result is 1.
- R9: A store at offset 0x800–0xBFF pulses notify without changing the state on an even page. On an odd page it is rejected.
- R10: `pq_wr_en` is asserted in the request cycle only for an accepted access whose new state differs from the stored state, and it carries that new state.
- R11: An access is rejected when the index is not below NUM_DESC, when `pq_rd_desc_ok` is 0, or when it is a store at offset 0xC00–0xFFF. A rejected access writes nothing and raises no notify, and a rejected load returns all ones.
- R12: `rsp_valid` pulses exactly one cycle after every load. `ntf_valid`, with its index and page parity, pulses one cycle after a notifying store.
- R13: While reset is held and after it is released with no request, `rsp_valid`, `ntf_valid` and `pq_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page64 | input | 1 | 1 selects 64 KB pages, 0 selects 4 KB pages |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Byte address within the page window |
| pq_rd_idx | output | IDX_W | Descriptor index presented to the state store |
| pq_rd_odd | output | 1 | Page parity presented to the state store |
| pq_rd_val | input | 2 | Stored state {P,Q} for the addressed field |
| pq_rd_desc_ok | input | 1 | Addressed descriptor is valid |
| pq_wr_en | output | 1 | Write the state store this cycle |
| pq_wr_idx | output | IDX_W | Descriptor index to write |
| pq_wr_odd | output | 1 | Page parity to write |
| pq_wr_val | output | 2 | New state {P,Q} |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Load data |
| ntf_valid | output | 1 | Notify pulse |
| ntf_idx | output | IDX_W | Descriptor index of the notify |
| ntf_odd | output | 1 | Page parity of the notify |

## Verification
The assertions assume that the state store answers combinationally: `pq_rd_val` and `pq_rd_desc_ok` must reflect the index and parity driven in the same cycle, and a write must land at the next clock edge. The bench keeps its store as an array read through continuous assignments and written on the clock edge, so this assumption holds. The bench also holds `cfg_page64` steady while requests are in flight and changes it only when idle, so the decoded page parity never shifts under a response that is still pending.

// File: rtl/pq_esb_pkg.sv
package pq_esb_pkg;

  typedef logic [1:0] pq_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LD_EOI,
    OP_LD_GET,
    OP_LD_SET,
    OP_ST_TRIG,
    OP_ST_EOI,
    OP_ST_INJ
  } esb_op_e;

  typedef struct packed {
    pq_t  pq;
    logic fire;
  } pq_step_t;

  // P is bit 1, Q is bit 0
  function automatic pq_step_t f_trigger(pq_t cur);
    pq_step_t s;
    s.pq   = cur;
    s.fire = 1'b0;
    case (cur)
      2'b00: begin s.pq = 2'b10; s.fire = 1'b1; end
      2'b10: s.pq = 2'b11;
      default: s.pq = cur;
    endcase
    return s;
  endfunction

  function automatic pq_step_t f_eoi(pq_t cur);
    pq_step_t s;
    s.fire = cur[0];
    s.pq   = cur[0] ? 2'b10 : 2'b00;
    return s;
  endfunction

endpackage

// File: rtl/pq_addr_decode.sv
module pq_addr_decode
  import pq_esb_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_DESC    = 12,
  parameter int IDX_W       = 4,
  parameter int SHIFT_SMALL = 12,
  parameter int SHIFT_LARGE = 16
) (
  input  logic              cfg_page64,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  idx,
  output logic              odd,
  output logic              in_range,
  output esb_op_e           op,
  output pq_t               set_val
);

  localparam int OFF_W = 12;

  logic [ADDR_W-1:0] full_small;
  logic [ADDR_W-1:0] full_large;
  logic [ADDR_W-1:0] full_idx;
  logic [OFF_W-1:0]  offset;

  assign full_small = req_addr >> (SHIFT_SMALL + 1);
  assign full_large = req_addr >> (SHIFT_LARGE + 1);
  assign full_idx   = cfg_page64 ? full_large : full_small;
  assign in_range   = full_idx < ADDR_W'(NUM_DESC);
  assign idx        = full_idx[IDX_W-1:0];
  assign odd        = cfg_page64 ? req_addr[SHIFT_LARGE] : req_addr[SHIFT_SMALL];
  assign offset     = req_addr[OFF_W-1:0];
  assign set_val    = offset[9:8];

  always_comb begin
    op = OP_NONE;
    if (!req_write) begin
      case (offset[11:10])
        2'b00, 2'b01: op = OP_LD_EOI;
        2'b10:        op = OP_LD_GET;
        default:      op = OP_LD_SET;
      endcase
    end else begin
      case (offset[11:10])
        2'b00:   op = OP_ST_TRIG;
        2'b01:   op = OP_ST_EOI;
        2'b10:   op = OP_ST_INJ;
        default: op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/pq_op_engine.sv
module pq_op_engine
  import pq_esb_pkg::*;
(
  input  logic    req_valid,
  input  esb_op_e op,
  input  pq_t     cur_pq,
  input  pq_t     set_val,
  input  logic    odd,
  input  logic    base_ok,
  output pq_t     nxt_pq,
  output logic    fire,
  output logic    reject,
  output pq_t     ld_bits,
  output logic    wr_en
);

  pq_step_t step_trig;
  pq_step_t step_eoi;

  assign step_trig = f_trigger(cur_pq);
  assign step_eoi  = f_eoi(cur_pq);

  always_comb begin
    nxt_pq  = cur_pq;
    fire    = 1'b0;
    ld_bits = 2'b00;
    reject  = !base_ok;
    case (op)
      OP_LD_EOI: begin
        nxt_pq  = step_eoi.pq;
        ld_bits = {1'b0, step_eoi.fire};
      end
      OP_LD_GET: ld_bits = cur_pq;
      OP_LD_SET: begin
        nxt_pq  = set_val;
        ld_bits = cur_pq;
      end
      OP_ST_TRIG: begin
        nxt_pq = step_trig.pq;
        fire   = step_trig.fire;
      end
      OP_ST_EOI: begin
        nxt_pq = step_eoi.pq;
        fire   = step_eoi.fire;
      end
      OP_ST_INJ: begin
        if (odd) reject = 1'b1;
        else     fire   = 1'b1;
      end
      default: reject = 1'b1;
    endcase
    if (reject) begin
      nxt_pq = cur_pq;
      fire   = 1'b0;
    end
  end

  assign wr_en = req_valid && !reject && (nxt_pq != cur_pq);

endmodule

// File: rtl/pq_rsp_reg.sv
module pq_rsp_reg
  import pq_esb_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              reject,
  input  logic              fire,
  input  pq_t               ld_bits,
  input  logic [IDX_W-1:0]  idx,
  input  logic              odd,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ntf_valid,
  output logic [IDX_W-1:0]  ntf_idx,
  output logic              ntf_odd
);

  logic              rsp_valid_d;
  logic              ntf_valid_d;
  logic [DATA_W-1:0] rsp_data_d;
  logic              rsp_en;
  logic              ntf_en;

  always_comb begin
    rsp_valid_d = req_valid && !req_write;
    ntf_valid_d = req_valid && req_write && fire;
    rsp_en      = rsp_valid_d;
    ntf_en      = ntf_valid_d;
    rsp_data_d  = reject ? {DATA_W{1'b1}} : {{(DATA_W-2){1'b0}}, ld_bits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      ntf_valid <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      ntf_valid <= ntf_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (rsp_en) begin
      rsp_data <= rsp_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntf_idx <= '0;
      ntf_odd <= 1'b0;
    end else if (ntf_en) begin
      ntf_idx <= idx;
      ntf_odd <= odd;
    end
  end

  assert_ntf_not_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> !rsp_valid);

  assert_ntf_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> $past(req_valid && req_write));

  assert_rsp_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

endmodule

// File: rtl/pq_page_ctrl.sv
module pq_page_ctrl
  import pq_esb_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 64,
  parameter int NUM_DESC    = 12,
  parameter int SHIFT_SMALL = 12,
  parameter int SHIFT_LARGE = 16,
  localparam int IDX_W      = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_page64,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  pq_rd_idx,
  output logic              pq_rd_odd,
  input  logic [1:0]        pq_rd_val,
  input  logic              pq_rd_desc_ok,
  output logic              pq_wr_en,
  output logic [IDX_W-1:0]  pq_wr_idx,
  output logic              pq_wr_odd,
  output logic [1:0]        pq_wr_val,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ntf_valid,
  output logic [IDX_W-1:0]  ntf_idx,
  output logic              ntf_odd
);

  logic [IDX_W-1:0] dec_idx;
  logic             dec_odd;
  logic             dec_in_range;
  esb_op_e          dec_op;
  pq_t              dec_set;
  pq_t              eng_nxt;
  logic             eng_fire;
  logic             eng_reject;
  pq_t              eng_ld;
  logic             eng_wr;

  pq_addr_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_DESC   (NUM_DESC),
    .IDX_W      (IDX_W),
    .SHIFT_SMALL(SHIFT_SMALL),
    .SHIFT_LARGE(SHIFT_LARGE)
  ) u_dec (
    .cfg_page64(cfg_page64),
    .req_write (req_write),
    .req_addr  (req_addr),
    .idx       (dec_idx),
    .odd       (dec_odd),
    .in_range  (dec_in_range),
    .op        (dec_op),
    .set_val   (dec_set)
  );

  pq_op_engine u_eng (
    .req_valid(req_valid),
    .op       (dec_op),
    .cur_pq   (pq_rd_val),
    .set_val  (dec_set),
    .odd      (dec_odd),
    .base_ok  (dec_in_range && pq_rd_desc_ok),
    .nxt_pq   (eng_nxt),
    .fire     (eng_fire),
    .reject   (eng_reject),
    .ld_bits  (eng_ld),
    .wr_en    (eng_wr)
  );

  pq_rsp_reg #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .reject   (eng_reject),
    .fire     (eng_fire),
    .ld_bits  (eng_ld),
    .idx      (dec_idx),
    .odd      (dec_odd),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .ntf_valid(ntf_valid),
    .ntf_idx  (ntf_idx),
    .ntf_odd  (ntf_odd)
  );

  assign pq_rd_idx = dec_idx;
  assign pq_rd_odd = dec_odd;
  assign pq_wr_en  = eng_wr;
  assign pq_wr_idx = dec_idx;
  assign pq_wr_odd = dec_odd;
  assign pq_wr_val = eng_nxt;

  assert_wb_changed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pq_wr_en |-> (pq_wr_val != pq_rd_val));

  assert_wb_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pq_wr_en |-> (req_valid && pq_rd_desc_ok));

  assert_get_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[11:10] == 2'b10) |-> !pq_wr_en);

  assert_undef_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[11:10] == 2'b11) |=> !ntf_valid);

  assert_inj_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[11:10] == 2'b10 && pq_rd_odd) |=> !ntf_valid);

  assert_ld_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

endmodule

// File: tb/sim_pq_page_ctrl.sv
module sim_pq_page_ctrl;

  localparam int AW = 24;
  localparam int DW = 64;
  localparam int ND = 12;
  localparam int IW = 4;

  logic          clk;
  logic          rst_n;
  logic          cfg_page64;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [IW-1:0] pq_rd_idx;
  logic          pq_rd_odd;
  logic [1:0]    pq_rd_val;
  logic          pq_rd_desc_ok;
  logic          pq_wr_en;
  logic [IW-1:0] pq_wr_idx;
  logic          pq_wr_odd;
  logic [1:0]    pq_wr_val;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          ntf_valid;
  logic [IW-1:0] ntf_idx;
  logic          ntf_odd;

  int vectors;
  int miscompares;
  int cyc;

  logic [1:0] store_mem [16][2];
  logic [1:0] ref_pq    [16][2];
  bit         dok       [16];

  pq_page_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_page64(cfg_page64),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .pq_rd_idx(pq_rd_idx), .pq_rd_odd(pq_rd_odd), .pq_rd_val(pq_rd_val),
    .pq_rd_desc_ok(pq_rd_desc_ok), .pq_wr_en(pq_wr_en), .pq_wr_idx(pq_wr_idx),
    .pq_wr_odd(pq_wr_odd), .pq_wr_val(pq_wr_val), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .ntf_valid(ntf_valid), .ntf_idx(ntf_idx), .ntf_odd(ntf_odd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign pq_rd_val     = store_mem[pq_rd_idx][pq_rd_odd];
  assign pq_rd_desc_ok = dok[pq_rd_idx];

  always @(posedge clk) begin
    if (pq_wr_en) store_mem[pq_wr_idx][pq_wr_odd] <= pq_wr_val;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog expired act=%0d exp<=60000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(int idx, int odd, int off, bit big);
    int sh = big ? 16 : 12;
    return AW'((longint'(idx) << (sh + 1)) | (longint'(odd) << sh) | longint'(off));
  endfunction

  // one access per clock; comb write port checked before the edge,
  // registered response checked after it
  task automatic access(bit we, logic [AW-1:0] a, string tag);
    int  sh, odd, off, ix, cur, nxt, ret;
    longint full;
    bit  rej, fire, ewr;
    logic [63:0] edata;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = we;
    req_addr  = a;
    #1;
    sh   = cfg_page64 ? 16 : 12;
    full = longint'(a) >> (sh + 1);
    odd  = int'((a >> sh) & 1);
    off  = int'(a & 'hFFF);
    ix   = int'(full & 15);
    cur  = int'(ref_pq[ix][odd]);
    rej  = !(full < ND && dok[ix]);
    nxt  = cur;
    fire = 1'b0;
    ret  = 0;
    if (!we) begin
      if (off < 'h800) begin
        ret = cur & 1;
        nxt = (cur & 1) ? 2 : 0;
      end else if (off < 'hC00) begin
        ret = cur;
      end else begin
        ret = cur;
        nxt = (off >> 8) & 3;
      end
    end else begin
      if (off < 'h400) begin
        if (cur == 0) begin nxt = 2; fire = 1'b1; end
        else if (cur == 2) nxt = 3;
      end else if (off < 'h800) begin
        fire = (cur & 1) != 0;
        nxt  = (cur & 1) ? 2 : 0;
      end else if (off < 'hC00) begin
        if (odd != 0) rej = 1'b1;
        else          fire = 1'b1;
      end else begin
        rej = 1'b1;
      end
    end
    if (rej) begin nxt = cur; fire = 1'b0; end
    ewr = !rej && (nxt != cur);
    chk($sformatf("R10 %s wr_en", tag), 64'(pq_wr_en), 64'(ewr));
    if (ewr) begin
      chk($sformatf("R1 %s wr_idx", tag), 64'(pq_wr_idx), 64'(ix));
      chk($sformatf("R1 %s wr_odd", tag), 64'(pq_wr_odd), 64'(odd));
      chk($sformatf("%s wr_val", tag), 64'(pq_wr_val), 64'(nxt));
      ref_pq[ix][odd] = 2'(nxt);
    end
    edata = rej ? '1 : 64'(ret);
    @(posedge clk);
    #2;
    chk($sformatf("R12 %s rsp_valid", tag), 64'(rsp_valid), 64'(!we));
    if (!we) chk($sformatf("%s rsp_data", tag), rsp_data, edata);
    chk($sformatf("R12 %s ntf_valid", tag), 64'(ntf_valid), 64'(we && fire));
    if (we && fire) begin
      chk($sformatf("R12 %s ntf_idx", tag), 64'(ntf_idx), 64'(ix));
      chk($sformatf("R12 %s ntf_odd", tag), 64'(ntf_odd), 64'(odd));
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
  endtask

  initial begin
    vectors     = 0;
    miscompares = 0;
    cyc         = 0;
    for (int i = 0; i < 16; i++) begin
      dok[i] = 1'b1;
      for (int j = 0; j < 2; j++) begin
        store_mem[i][j] = 2'b00;
        ref_pq[i][j]    = 2'b00;
      end
    end
    dok[5]     = 1'b0;
    rst_n      = 1'b0;
    cfg_page64 = 1'b0;
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_addr   = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R13 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R13 ntf_valid in reset", 64'(ntf_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R13 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R13 ntf_valid after reset", 64'(ntf_valid), 64'd0);
    chk("R13 wr_en after reset", 64'(pq_wr_en), 64'd0);

    // trigger chain, 4 KB pages
    access(1, mk(0, 0, 'h000, 0), "R2 R7 trig 00");
    access(1, mk(0, 0, 'h3FC, 0), "R2 R7 trig 10");
    access(1, mk(0, 0, 'h100, 0), "R2 R7 trig 11");
    access(0, mk(1, 1, 'hD00, 0), "R6 set 01");
    access(1, mk(1, 1, 'h000, 0), "R2 trig 01 odd");
    access(0, mk(1, 1, 'h800, 0), "R5 get odd 01");
    access(0, mk(0, 0, 'h9F0, 0), "R5 get 11");
    // load EOI
    access(0, mk(0, 0, 'h000, 0), "R3 R4 ld eoi 11");
    access(0, mk(0, 0, 'h7F8, 0), "R3 R4 ld eoi 10");
    access(0, mk(0, 0, 'h800, 0), "R5 get 00");
    // store EOI
    access(0, mk(2, 0, 'hF00, 0), "R6 set 11");
    access(1, mk(2, 0, 'h400, 0), "R3 R8 st eoi 11");
    access(1, mk(2, 0, 'h7FF, 0), "R3 R8 st eoi 10");
    access(0, mk(2, 0, 'hE00, 0), "R6 set 10");
    access(0, mk(2, 0, 'hC00, 0), "R6 set 00");
    // inject
    access(1, mk(3, 0, 'h800, 0), "R9 inject even");
    access(1, mk(3, 1, 'hA00, 0), "R9 inject odd");
    access(0, mk(3, 1, 'h800, 0), "R9 get after odd inject");
    // rejects
    access(0, mk(5, 0, 'h800, 0), "R11 ld invalid desc");
    access(1, mk(5, 0, 'h000, 0), "R11 st invalid desc");
    access(0, mk(13, 0, 'h800, 0), "R11 ld index 13");
    access(1, mk(40, 1, 'h000, 0), "R11 st index 40");
    access(0, mk(40, 1, 'hF00, 0), "R11 ld index 40");
    access(1, mk(4, 0, 'hC00, 0), "R11 st undef");
    access(0, mk(4, 0, 'h800, 0), "R11 get after undef");
    idle();

    // 64 KB pages, with junk in bits 15:12
    cfg_page64 = 1'b1;
    access(1, mk(11, 1, 'h000, 1) | AW'('h5000), "R1 big trig odd");
    access(0, mk(11, 1, 'h800, 1) | AW'('hA000), "R1 big get odd");
    access(0, mk(11, 0, 'h800, 1), "R1 big get even");
    access(1, mk(6, 0, 'h800, 1) | AW'('hF000), "R1 big inject");
    access(0, mk(12, 0, 'h800, 1), "R1 R11 big index 12");
    idle();

    for (int n = 0; n < 400; n++) begin
      bit big = (n % 100) >= 50;
      if (big != cfg_page64) begin
        idle();
        cfg_page64 = big;
      end
      access(bit'($urandom_range(0, 1)),
             mk(int'($urandom_range(0, 13)), int'($urandom_range(0, 1)),
                int'($urandom_range(0, 'hFFF)), big),
             "R1 R2 R3 R6 mix");
    end
    idle();
    @(posedge clk);
    #2;
    chk("R13 quiet after idle", 64'(ntf_valid | rsp_valid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule